// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block provides the bit-level timing for a CAN-style serial controller. A programmable prescaler divides the system clock into time quanta. A sequencer steps each bit through four segments: a one-quantum sync segment, a propagation segment, a first phase segment and a second phase segment. The sample point falls at the end of the first phase segment. At that point the block samples the receive line and reports the value together with a one-cycle strobe. Separately, it marks the first clock cycle of every bit.

Configuration is written through a small register port, and only while the configuration-mode input is high. While that input is high, the timing is held idle. When it is released, timing starts from the beginning of a sync segment. The second phase segment can be set explicitly or derived from the first phase segment. Sampling can use one read or a three-read majority vote. A falling (recessive-to-dominant) edge on the receive line moves the bit boundary by up to the jump width: the first phase segment is lengthened, or the second phase segment is shortened.

Top module: `cbt_bit_timer`

## Requirements
- R1: One time quantum lasts 2*(P+1) clock cycles, where P is the 6-bit prescale field, bits [5:0] of register 0.
- R2: A bit is 1 + Lp + L1 + L2 quanta long. Lp, L1 and L2 are the segment lengths, each programmed as length minus one in a 3-bit field. Lp is in register 1 bits [2:0], L1 in register 1 bits [5:3] and the explicit L2 in register 2 bits [2:0]. `bit_start` is high for exactly the first clock cycle of each sync segment.
- R3: `sample_stb` is high for one cycle, exactly (1 + Lp + L1) quanta after the matching `bit_start` cycle when no resynchronization occurs.
- R4: With register 1 bit 6 = 0, `rx_bit` takes the value of `rx_in` in the last clock cycle of the first phase segment.
- R5: With register 1 bit 6 = 1, `rx_bit` is the majority of three reads of `rx_in`. The first is taken in the mid-quantum cycle (count P) of the last quantum of the first phase segment, the second in the cycle after it, and the third in the last cycle of that segment.
- R6: With register 1 bit 7 = 1, L2 comes from register 2. With bit 7 = 0, register 2 has no effect and L2 = max(L1, 2).
- R7: Writes (`cfg_wr`, `cfg_sel`, `cfg_wdata`) take effect only while `cfg_mode` is 1. In normal mode they change nothing. Register 0 bits [7:6] hold the jump width minus one.
- R8: While `cfg_mode` is 1, no strobes appear. After release, the first cycle is the first cycle of a sync segment, so the first `bit_start` follows one full bit later.
- R9: A falling edge of `rx_in` in bit quantum m (sync = 0), inside the propagation or first phase segment, lengthens the first phase segment by min(m, SJW) quanta.
- R10: A falling edge in quantum q (counted from 0) of the second phase segment shortens that segment by min(L2-1-q, SJW) quanta.
- R11: Falling edges in the sync segment, rising edges, and any edge after the first acted-on edge within the same bit have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 1 | Configuration mode: allows writes and holds timing idle |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0, 1, 2) |
| cfg_wdata | input | 8 | Register write data |
| rx_in | input | 1 | Receive line, 1 = recessive |
| sample_stb | output | 1 | One-cycle strobe at the sample point |
| rx_bit | output | 1 | Sampled bit value, valid from the strobe on |
| bit_start | output | 1 | One-cycle strobe in the first cycle of each bit |

## Verification
The assertions take for granted that software programs a legal bit: the propagation segment plus the first phase segment must be at least as long as the second phase segment, and the second phase segment must be no shorter than the jump width. One assertion flags any running configuration that breaks this rule. The sweeps and resynchronization cases only build configurations that meet it. The bench also takes for granted that `rx_in` holds steady across each clock edge, and it drives the line only at falling clock edges. In the sampling cases, the line is pulled dominant only inside the sync segment, so those cases never trigger resynchronization by accident.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
    localparam int BRP_W   = 6;
    localparam int SJW_W   = 2;
    localparam int SEG_W   = 3;
    localparam int SEL_W   = 2;
    localparam int DATA_W  = BRP_W + SJW_W;
    localparam int LEN_W   = SEG_W + 2;
    localparam int EXT_W   = SJW_W + 1;
    localparam int CNT_W   = BRP_W + 1;
    localparam int IPT_TQ  = 2;

    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_PROP = 2'd1,
        SEG_PH1  = 2'd2,
        SEG_PH2  = 2'd3
    } seg_e;

    typedef struct packed {
        logic [BRP_W-1:0] brp;
        logic [SJW_W-1:0] sjw;
        logic [SEG_W-1:0] prop;
        logic [SEG_W-1:0] ph1;
        logic [SEG_W-1:0] ph2;
        logic             triple;
        logic             ph2_explicit;
    } cbt_cfg_t;

    typedef struct packed {
        seg_e             seg;
        logic [LEN_W-1:0] qcnt;
        logic [EXT_W-1:0] ext;
        logic [EXT_W-1:0] shr;
        logic             resynced;
        logic             rx_last;
        logic             sa;
        logic             sb;
        logic             mid_dly;
        logic             sample;
        logic             bit_start;
        logic             rx_bit;
    } seq_st_t;
endpackage

// File: rtl/cbt_cfg_regs.sv
module cbt_cfg_regs
    import cbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_mode,
    input  logic              cfg_wr,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output cbt_cfg_t          cfg
);
    cbt_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_mode && cfg_wr) begin
            case (cfg_sel)
                2'd0: begin
                    cfg_d.brp = cfg_wdata[BRP_W-1:0];
                    cfg_d.sjw = cfg_wdata[BRP_W +: SJW_W];
                end
                2'd1: begin
                    cfg_d.prop         = cfg_wdata[0 +: SEG_W];
                    cfg_d.ph1          = cfg_wdata[SEG_W +: SEG_W];
                    cfg_d.triple       = cfg_wdata[2*SEG_W];
                    cfg_d.ph2_explicit = cfg_wdata[2*SEG_W+1];
                end
                2'd2: cfg_d.ph2 = cfg_wdata[0 +: SEG_W];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    // R7: outside configuration mode the settings never move
    p_cfg_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mode |=> $stable(cfg_q));
endmodule

// File: rtl/cbt_prescaler.sv
module cbt_prescaler
    import cbt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [BRP_W-1:0] brp,
    output logic             tq_end,
    output logic             tq_mid
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] last_c;

    always_comb begin
        last_c = {brp, 1'b1};
        tq_end = run && (cnt_q == last_c);
        tq_mid = run && (cnt_q == {1'b0, brp});
        if (!run || tq_end) cnt_d = '0;
        else                cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R1: a quantum always spans at least two cycles
    p_tq_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tq_end |=> !tq_end);
    p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= last_c));
endmodule

// File: rtl/cbt_seg_sequencer.sv
module cbt_seg_sequencer
    import cbt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tq_end,
    input  logic             tq_mid,
    input  logic             rx_in,
    input  logic [SJW_W-1:0] sjw,
    input  logic [SEG_W-1:0] prop,
    input  logic [SEG_W-1:0] ph1,
    input  logic [SEG_W-1:0] ph2,
    input  logic             triple,
    input  logic             ph2_explicit,
    output logic             sample_stb,
    output logic             rx_bit,
    output logic             bit_start
);
    seq_st_t st_d, st_q;

    logic [LEN_W-1:0] len_prop, len_ph1, len_ph2, qnext;
    logic [EXT_W-1:0] sjw_len, clamp_c, ext_eff, shr_eff;
    logic [LEN_W-1:0] err_c;
    logic             edge_c, ph1_end, ph2_end, sb_now, vote_c;

    function automatic logic [EXT_W-1:0] clamp_err(input logic [LEN_W-1:0] err,
                                                   input logic [EXT_W-1:0] lim);
        if (err < LEN_W'(lim)) return EXT_W'(err);
        return lim;
    endfunction

    always_comb begin
        len_prop = LEN_W'(prop) + LEN_W'(1);
        len_ph1  = LEN_W'(ph1) + LEN_W'(1);
        if (ph2_explicit)              len_ph2 = LEN_W'(ph2) + LEN_W'(1);
        else if (len_ph1 > LEN_W'(IPT_TQ)) len_ph2 = len_ph1;
        else                           len_ph2 = LEN_W'(IPT_TQ);
        sjw_len = EXT_W'(sjw) + EXT_W'(1);
        qnext   = st_q.qcnt + LEN_W'(1);

        edge_c = run && st_q.rx_last && !rx_in && !st_q.resynced
                 && (st_q.seg != SEG_SYNC);
        case (st_q.seg)
            SEG_PROP: err_c = qnext;
            SEG_PH1:  err_c = len_prop + qnext;
            SEG_PH2:  err_c = len_ph2 - qnext;
            default:  err_c = '0;
        endcase
        clamp_c = clamp_err(err_c, sjw_len);

        ext_eff = (edge_c && st_q.seg != SEG_PH2) ? clamp_c : st_q.ext;
        shr_eff = (edge_c && st_q.seg == SEG_PH2) ? clamp_c : st_q.shr;
        ph1_end = qnext >= (len_ph1 + LEN_W'(ext_eff));
        ph2_end = qnext >= (len_ph2 - LEN_W'(shr_eff));

        sb_now = st_q.mid_dly ? rx_in : st_q.sb;
        vote_c = triple ? ((st_q.sa & sb_now) | (st_q.sa & rx_in) | (sb_now & rx_in))
                        : rx_in;

        st_d           = st_q;
        st_d.sample    = 1'b0;
        st_d.bit_start = 1'b0;
        st_d.rx_last   = rx_in;
        st_d.mid_dly   = tq_mid;

        if (!run) begin
            st_d.seg      = SEG_SYNC;
            st_d.qcnt     = '0;
            st_d.ext      = '0;
            st_d.shr      = '0;
            st_d.resynced = 1'b0;
            st_d.mid_dly  = 1'b0;
        end else begin
            if (edge_c) begin
                st_d.resynced = 1'b1;
                if (st_q.seg == SEG_PH2) st_d.shr = clamp_c;
                else                     st_d.ext = clamp_c;
            end
            if (st_q.seg == SEG_PH1) begin
                if (tq_mid)       st_d.sa = rx_in;
                if (st_q.mid_dly) st_d.sb = rx_in;
            end
            if (tq_end) begin
                case (st_q.seg)
                    SEG_SYNC: begin
                        st_d.seg  = SEG_PROP;
                        st_d.qcnt = '0;
                    end
                    SEG_PROP: begin
                        if (qnext >= len_prop) begin
                            st_d.seg  = SEG_PH1;
                            st_d.qcnt = '0;
                        end else st_d.qcnt = qnext;
                    end
                    SEG_PH1: begin
                        if (ph1_end) begin
                            st_d.seg    = SEG_PH2;
                            st_d.qcnt   = '0;
                            st_d.sample = 1'b1;
                            st_d.rx_bit = vote_c;
                        end else st_d.qcnt = qnext;
                    end
                    default: begin
                        if (ph2_end) begin
                            st_d.seg       = SEG_SYNC;
                            st_d.qcnt      = '0;
                            st_d.ext       = '0;
                            st_d.shr       = '0;
                            st_d.resynced  = 1'b0;
                            st_d.bit_start = 1'b1;
                        end else st_d.qcnt = qnext;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.rx_last <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sample_stb = st_q.sample;
    assign rx_bit     = st_q.rx_bit;
    assign bit_start  = st_q.bit_start;

    // R2: a bit boundary strobe only marks the opening cycle of sync
    p_start_in_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_start |-> (st_q.seg == SEG_SYNC && st_q.qcnt == '0));
    // R3: the sample strobe marks the move from phase 1 into phase 2
    p_sample_at_ph1_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> (st_q.seg == SEG_PH2 && $past(st_q.seg) == SEG_PH1));
    p_strobes_apart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_stb && bit_start));
    // R6: legal programming is an input assumption
    p_cfg_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> ((len_prop + len_ph1 >= len_ph2) && (len_ph2 >= LEN_W'(sjw_len))));
    // R8: idle while configuring
    p_idle_in_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!sample_stb && !bit_start));
    // R9 / R10: corrections never exceed the jump width
    p_ext_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ext <= sjw_len);
    p_shr_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.shr <= sjw_len);
    // R11: once a bit has been corrected, further edges change nothing
    p_single_resync_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (run && st_q.resynced && !(tq_end && st_q.seg == SEG_PH2))
        |=> ($stable(st_q.ext) && $stable(st_q.shr)));
endmodule

// File: rtl/cbt_bit_timer.sv
module cbt_bit_timer
    import cbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_mode,
    input  logic              cfg_wr,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              rx_in,
    output logic              sample_stb,
    output logic              rx_bit,
    output logic              bit_start
);
    cbt_cfg_t cfg;
    logic     run, tq_end, tq_mid;

    assign run = !cfg_mode;

    cbt_cfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_wr(cfg_wr),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg(cfg)
    );

    cbt_prescaler u_presc (
        .clk(clk), .rst_n(rst_n), .run(run), .brp(cfg.brp),
        .tq_end(tq_end), .tq_mid(tq_mid)
    );

    cbt_seg_sequencer u_seq (
        .clk(clk), .rst_n(rst_n), .run(run), .tq_end(tq_end), .tq_mid(tq_mid),
        .rx_in(rx_in), .sjw(cfg.sjw), .prop(cfg.prop), .ph1(cfg.ph1),
        .ph2(cfg.ph2), .triple(cfg.triple), .ph2_explicit(cfg.ph2_explicit),
        .sample_stb(sample_stb), .rx_bit(rx_bit), .bit_start(bit_start)
    );
endmodule

// File: tb/tb_cbt_bit_timer.sv
module tb_cbt_bit_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_mode = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [7:0] cfg_wdata = '0;
    logic       rx_in = 1'b1;
    logic       sample_stb, rx_bit, bit_start;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    cbt_bit_timer dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_wr(cfg_wr),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .rx_in(rx_in),
        .sample_stb(sample_stb), .rx_bit(rx_bit), .bit_start(bit_start)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int sel, input logic [7:0] data);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = 2'(sel); cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic configure(input int brp, input int sjw, input int prop, input int ph1,
                             input int ph2, input bit triple, input bit expl);
        @(negedge clk);
        cfg_mode = 1'b1;
        wr(0, {2'(sjw - 1), 6'(brp)});
        wr(1, {expl, triple, 3'(ph1 - 1), 3'(prop - 1)});
        wr(2, {5'd0, 3'(ph2 - 1)});
        @(negedge clk);
        cfg_mode = 1'b0;
    endtask

    task automatic wait_start();
        int g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!bit_start && g < 3000);
    endtask

    task automatic measure(output int off, output int per);
        int k = 0;
        off = -1; per = -1;
        wait_start();
        while (k < 3000) begin
            @(negedge clk);
            k++;
            if (sample_stb && off < 0) off = k;
            if (bit_start) begin per = k; break; end
        end
    endtask

    function automatic int ph2_len(input int ph1, input int ph2, input bit expl);
        if (expl) return ph2;
        return (ph1 > 2) ? ph1 : 2;
    endfunction

    task automatic timing_case(input int brp, input int prop, input int ph1,
                               input int ph2, input bit expl, input string tag);
        int off, per, q, l2;
        configure(brp, 1, prop, ph1, ph2, 1'b0, expl);
        measure(off, per);
        q  = 2 * (brp + 1);
        l2 = ph2_len(ph1, ph2, expl);
        check(off == (1 + prop + ph1) * q, {tag, " R3 sample offset"}, off, (1 + prop + ph1) * q);
        check(per == (1 + prop + ph1 + l2) * q, {tag, " R2 bit period"}, per, (1 + prop + ph1 + l2) * q);
    endtask

    task automatic sample_case(input bit a, input bit b, input bit c, input bit exp,
                               input string tag);
        int k = 0;
        bit seen = 0;
        wait_start();
        while (k < 100) begin
            @(negedge clk);
            k++;
            if (k == 2)  rx_in = 1'b0;
            if (k == 94) rx_in = a;
            if (k == 95) rx_in = b;
            if (k == 96) rx_in = c;
            if (k == 100) begin
                seen = sample_stb;
                check(sample_stb && rx_bit == exp, tag, int'(rx_bit), int'(exp));
            end
        end
        if (!seen) check(1'b0, {tag, " strobe"}, 0, 1);
        rx_in = 1'b1;
    endtask

    task automatic resync_case(input int sjw, input int m, input int fall2, input string tag);
        int k = 0, off = -1, per = -1, ext = 0, shr = 0, e;
        wait_start();
        if (m == 0) rx_in = 1'b0;
        while (k < 200) begin
            @(negedge clk);
            k++;
            if (k == 2 * m) rx_in = 1'b0;
            if (fall2 > 0 && k == 2 * fall2 - 2) rx_in = 1'b1;
            if (fall2 > 0 && k == 2 * fall2) rx_in = 1'b0;
            if (sample_stb && off < 0) off = k;
            if (bit_start) begin per = k; break; end
        end
        rx_in = 1'b1;
        if (m >= 1 && m <= 5) ext = (m < sjw) ? m : sjw;
        if (m >= 6) begin
            e   = 4 - (m - 6) - 1;
            shr = (e < sjw) ? e : sjw;
        end
        check(off == (6 + ext) * 2, {tag, " offset"}, off, (6 + ext) * 2);
        check(per == (10 + ext - shr) * 2, {tag, " period"}, per, (10 + ext - shr) * 2);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL watchdog expired actual=1 expected=0");
        n_fail++;
        n_tests++;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int off, per, cnt;
        cfg_mode = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!sample_stb && !bit_start && !rx_bit, "reset outputs idle", int'(sample_stb), 0);

        // R2 R3 R1: reference bit of 16 quanta, 160 cycles = 8 us at 20 MHz with P=4
        timing_case(4, 2, 7, 6, 1'b1, "ref16");
        // R6: derived phase 2 ignores register 2
        timing_case(4, 2, 7, 1, 1'b0, "R6 derived ph1=7");
        timing_case(4, 1, 1, 8, 1'b0, "R6 derived floor 2");
        // R1: largest prescale
        timing_case(63, 1, 1, 1, 1'b0, "R1 brp63");

        // near-exhaustive sweep over small settings
        for (int bi = 0; bi < 3; bi++) begin
            for (int p = 1; p <= 3; p++) begin
                for (int f = 1; f <= 4; f++) begin
                    timing_case((bi == 2) ? 4 : bi, p, f, 1, 1'b0, "R1 R2 R6 sweep derived");
                    for (int s = 1; s <= 4; s++) begin
                        if (s <= p + f)
                            timing_case((bi == 2) ? 4 : bi, p, f, s, 1'b1, "R1 R2 sweep explicit");
                    end
                end
            end
        end

        // R5: triple sampling majority
        configure(4, 1, 2, 7, 6, 1'b1, 1'b1);
        sample_case(0, 0, 1, 0, "R5 vote 001");
        sample_case(0, 1, 1, 1, "R5 vote 011");
        sample_case(0, 0, 0, 0, "R5 vote 000");
        sample_case(1, 1, 1, 1, "R5 vote 111");
        // R4: single sampling
        configure(4, 1, 2, 7, 6, 1'b0, 1'b1);
        sample_case(0, 0, 1, 1, "R4 single 001");
        sample_case(0, 1, 1, 1, "R4 single 011");
        sample_case(0, 0, 0, 0, "R4 single 000");

        // R7: writes outside configuration mode are ignored
        wr(0, 8'h00);
        wr(1, 8'h00);
        wr(2, 8'h00);
        measure(off, per);
        check(per == 160, "R7 write ignored period", per, 160);
        check(off == 100, "R7 write ignored offset", off, 100);

        // R8: idle while configuring, restart at sync
        @(negedge clk);
        cfg_mode = 1'b1;
        cnt = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (sample_stb || bit_start) cnt++;
        end
        check(cnt == 0, "R8 no strobes in config mode", cnt, 0);
        cfg_mode = 1'b0;
        cnt = 0;
        while (cnt < 1000) begin
            @(negedge clk);
            cnt++;
            if (bit_start) break;
        end
        check(cnt == 160, "R8 first bit after release", cnt, 160);

        // R9 R10 R11: resynchronization, Q=2, sync1 prop2 ph1 3 ph2 4
        for (int s = 1; s <= 4; s++) begin
            configure(0, s, 2, 3, 4, 1'b0, 1'b1);
            for (int m = 0; m <= 9; m++) begin
                resync_case(s, m, 0, (m == 0) ? "R11 sync edge" :
                                     (m <= 5) ? "R9 late edge" : "R10 early edge");
            end
        end
        configure(0, 4, 2, 3, 4, 1'b0, 1'b1);
        resync_case(4, 1, 7, "R11 second edge");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule